// File: doc/BRIEF.md
# Hot-Plug Slot Command Engine

This block runs the command path of a hot-plug controller for a bank of expansion slots. Software writes an 8-bit command code and a 5-bit slot target. Writing the code byte raises `cmd_wr_i` for one cycle. The engine decodes the code and checks that the requested slot transition is legal. It then updates each slot's state, power indicator, attention indicator, latch flag, presence field and event bits, and reports the result on three status flags and a sticky completion flag.

There are three command groups:

- **Single-slot commands** pack a requested state and two indicator values into the low six bits of the code.
- **Bus-speed commands** accept only the basic 33 MHz mode.
- **All-slot commands** first scan every slot. They abort if any slot is already enabled, and only then walk the slots one per cycle.

While a command runs, `busy_o` stays high and new code writes are dropped.

Slot fields come from `occupied_i` during a synchronous reset:

| Slot at reset | State | Power indicator | Latch | Presence |
|---|---|---|---|---|
| Occupied | enabled | on | closed | 0 |
| Empty | disabled | off | open | 3 |

Top module: `hpc_cmd_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, each slot loads from `occupied_i`. An occupied slot becomes state 2 (enabled) with power indicator 1 (on), latch closed and presence 0. An empty slot becomes state 3 (disabled) with power indicator 3 (off), latch open and presence 3. The attention indicator, the event bits, `inv_cmd_o`, `inv_mode_o`, `cmd_done_o` and `busy_o` all clear to 0.
- R2: Codes 0x00 to 0x3F address one slot. Code bits [1:0] give the requested state (0 keep, 1 power-only, 2 enabled, 3 disabled). Bits [3:2] give the power indicator and bits [5:4] give the attention indicator (0 keep, 1 on, 2 blink, 3 off). A nonzero indicator field is written to the slot, and a zero field leaves that indicator as it was.
- R3: For a single-slot command, only these state changes are made:
  - disabled to power-only;
  - disabled to enabled;
  - enabled or power-only to disabled.

  Other requests leave the state alone. A request for power-only on an enabled slot sets `inv_cmd_o` and changes no field of the slot.
- R4: A target of 0, or a target greater than NSLOTS, sets `inv_cmd_o` and changes no slot. Slot index i is addressed by target i+1.
- R5: Codes 0x40 to 0x47 change no slot. Bits [2:0] equal to 0 are accepted. Any other value sets `inv_mode_o`. `inv_mode_o` and `inv_cmd_o` are never both high.
- R6: Codes 0x4A to 0xFF set `inv_cmd_o` and change nothing else.
- R7: Code 0x48 (power-only all) and code 0x49 (enable all) set `inv_cmd_o` and change no slot if any slot is enabled.
- R8: Otherwise an all-slot command handles each slot in turn. A slot with its latch closed gets the target state (power-only for 0x48, enabled for 0x49), using the R3 rules, with the power indicator on. A slot with its latch open keeps its state and gets the power indicator off.
- R9: When a slot goes to disabled and its power indicator, after this command's indicator update, is off, the slot is marked empty: latch open, presence 3 and all three event bits set. In `slot_evt_o[3i+2:3i]`, bit 0 is presence, bit 1 is latch and bit 2 is button.
- R10: Accepting a command clears `inv_cmd_o` and `inv_mode_o`. Finishing any command, whether it succeeded or failed, sets `cmd_done_o`. `done_clr_i` clears `cmd_done_o`, but a finish in the same cycle wins.
- R11: `busy_o` rises on the edge that accepts `cmd_wr_i`. It stays high for:
  - 1 cycle for single-slot, speed and invalid codes;
  - k+1 cycles for an all-slot command that aborts at the lowest enabled slot index k;
  - 2*NSLOTS cycles for an all-slot command that completes.
- R12: `cmd_wr_i` while `busy_o` is high is ignored. The running command finishes unchanged, and the new code has no effect.
- R13: `evt_clr_i[i]` clears the three event bits of slot i. Marking the slot empty in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| occupied_i | input | NSLOTS | Per-slot occupancy, sampled during reset |
| cmd_wr_i | input | 1 | Command code byte written |
| cmd_code_i | input | 8 | Command code |
| cmd_target_i | input | 5 | Target slot (index + 1) |
| done_clr_i | input | 1 | Clear completion flag |
| evt_clr_i | input | NSLOTS | Per-slot event clear |
| busy_o | output | 1 | Command in progress |
| inv_cmd_o | output | 1 | Invalid-command status |
| inv_mode_o | output | 1 | Invalid-mode status |
| cmd_done_o | output | 1 | Sticky command-completed flag |
| slot_state_o | output | 2*NSLOTS | Slot states, 2 bits per slot |
| pwr_ind_o | output | 2*NSLOTS | Power indicators |
| attn_ind_o | output | 2*NSLOTS | Attention indicators |
| latch_open_o | output | NSLOTS | Latch open flags |
| presence_o | output | 2*NSLOTS | Presence codes |
| slot_evt_o | output | 3*NSLOTS | Event bits {button, latch, presence} per slot |

## Verification
The assertions assume the following:

- `rst_n` is held low for at least two clock edges, with `occupied_i` steady.
- All inputs are known outside reset.
- `cmd_wr_i` is a single-cycle pulse. The design does not need this, but the busy-timing checks count from it.

The stimulus pulses the write for one cycle and waits for `busy_o` to fall before the next command. The one exception is the directed test that holds the write high into a running all-slot command. Random stimulus mixes codes and targets with reset-time occupancy patterns. It leans on disable-with-power-on commands so that all-slot commands find closed latches and no enabled slot.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

   localparam logic [1:0] ST_KEEP = 2'd0;
   localparam logic [1:0] ST_PWR  = 2'd1;
   localparam logic [1:0] ST_EN   = 2'd2;
   localparam logic [1:0] ST_DIS  = 2'd3;

   localparam logic [1:0] IND_KEEP  = 2'd0;
   localparam logic [1:0] IND_ON    = 2'd1;
   localparam logic [1:0] IND_BLINK = 2'd2;
   localparam logic [1:0] IND_OFF   = 2'd3;

   localparam logic [1:0] PRES_LOW   = 2'd0;
   localparam logic [1:0] PRES_EMPTY = 2'd3;

   localparam int CODE_W = 8;
   localparam int TGT_W  = 5;
   localparam int EVT_W  = 3;

   typedef enum logic [1:0] {CK_SLOT, CK_SPEED, CK_ALL, CK_BAD} cmd_kind_e;
   typedef enum logic [1:0] {SQ_IDLE, SQ_EXEC, SQ_SCAN, SQ_APPLY} seq_e;

   function automatic cmd_kind_e classify(input logic [CODE_W-1:0] c);
      if (c[7:6] == 2'b00)               return CK_SLOT;
      if (c[7:3] == 5'b01000)            return CK_SPEED;
      if (c == 8'h48 || c == 8'h49)      return CK_ALL;
      return CK_BAD;
   endfunction

endpackage

// File: rtl/hpc_slot_cell.sv
module hpc_slot_cell
   import hpc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             occupied_i,
   input  logic             apply_i,
   input  logic [1:0]       req_state_i,
   input  logic [1:0]       req_pwr_i,
   input  logic [1:0]       req_attn_i,
   input  logic             evt_clr_i,
   output logic [1:0]       state_o,
   output logic [1:0]       pwr_o,
   output logic [1:0]       attn_o,
   output logic             latch_open_o,
   output logic [1:0]       presence_o,
   output logic [EVT_W-1:0] evt_o
);

   logic [1:0]       state_q, pwr_q, attn_q, pres_q;
   logic             latch_q;
   logic [EVT_W-1:0] evt_q;

   logic [1:0] nxt_pwr, nxt_attn;
   logic       go_on, go_off, mark_empty;

   always_comb begin
      nxt_pwr    = (req_pwr_i  != IND_KEEP) ? req_pwr_i  : pwr_q;
      nxt_attn   = (req_attn_i != IND_KEEP) ? req_attn_i : attn_q;
      go_on      = (state_q == ST_DIS) && (req_state_i == ST_PWR || req_state_i == ST_EN);
      go_off     = (state_q == ST_EN || state_q == ST_PWR) && (req_state_i == ST_DIS);
      mark_empty = apply_i && go_off && (nxt_pwr == IND_OFF);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         if (occupied_i) begin
            state_q <= ST_EN;
            pwr_q   <= IND_ON;
            latch_q <= 1'b0;
            pres_q  <= PRES_LOW;
         end else begin
            state_q <= ST_DIS;
            pwr_q   <= IND_OFF;
            latch_q <= 1'b1;
            pres_q  <= PRES_EMPTY;
         end
         attn_q <= IND_KEEP;
         evt_q  <= '0;
      end else begin
         if (apply_i) begin
            pwr_q  <= nxt_pwr;
            attn_q <= nxt_attn;
            if (go_on)  state_q <= req_state_i;
            if (go_off) state_q <= ST_DIS;
         end
         if (mark_empty) begin
            latch_q <= 1'b1;
            pres_q  <= PRES_EMPTY;
            evt_q   <= '1;
         end else if (evt_clr_i) begin
            evt_q   <= '0;
         end
      end
   end

   assign state_o      = state_q;
   assign pwr_o        = pwr_q;
   assign attn_o       = attn_q;
   assign latch_open_o = latch_q;
   assign presence_o   = pres_q;
   assign evt_o        = evt_q;

   // R3: power-only is never entered straight from enabled
   assert_no_en_to_pwr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PWR) |-> ($past(state_q) != ST_EN));

   // R9: a latch that opens always carries the empty presence code and all events
   assert_empty_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch_q) |-> (pres_q == PRES_EMPTY && evt_q == '1));

   // R2: without an apply the indicators hold
   assert_ind_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !apply_i |=> ($stable(pwr_q) && $stable(attn_q)));

endmodule

// File: rtl/hpc_cmd_seq.sv
module hpc_cmd_seq
   import hpc_pkg::*;
#(
   parameter int NSLOTS = 31,
   localparam int IDX_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [TGT_W-1:0]  target_i,
   input  logic              done_clr_i,
   input  logic [1:0]        sel_state_i,
   input  logic              sel_latch_i,
   output logic [IDX_W-1:0]  sel_idx_o,
   output logic              apply_o,
   output logic [1:0]        req_state_o,
   output logic [1:0]        req_pwr_o,
   output logic [1:0]        req_attn_o,
   output logic              busy_o,
   output logic              inv_cmd_o,
   output logic              inv_mode_o,
   output logic              done_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLOTS - 1);

   seq_e              st_q;
   logic [CODE_W-1:0] code_q;
   logic [TGT_W-1:0]  tgt_q;
   logic [IDX_W-1:0]  idx_q;
   logic              inv_cmd_q, inv_mode_q, done_q;

   cmd_kind_e kind;
   logic      tgt_ok, reject, finish, accept;

   always_comb begin
      kind   = classify(code_q);
      tgt_ok = (int'(tgt_q) >= 1) && (int'(tgt_q) <= NSLOTS);
      accept = cmd_wr_i && (st_q == SQ_IDLE);

      sel_idx_o   = idx_q;
      apply_o     = 1'b0;
      req_state_o = ST_KEEP;
      req_pwr_o   = IND_KEEP;
      req_attn_o  = IND_KEEP;
      reject      = 1'b0;

      if (st_q == SQ_EXEC) begin
         sel_idx_o   = IDX_W'(tgt_q - TGT_W'(1));
         req_state_o = code_q[1:0];
         req_pwr_o   = code_q[3:2];
         req_attn_o  = code_q[5:4];
         reject      = (sel_state_i == ST_EN) && (code_q[1:0] == ST_PWR);
         apply_o     = (kind == CK_SLOT) && tgt_ok && !reject;
      end else if (st_q == SQ_APPLY) begin
         apply_o = 1'b1;
         if (sel_latch_i) begin
            req_state_o = ST_KEEP;
            req_pwr_o   = IND_OFF;
         end else begin
            req_state_o = code_q[0] ? ST_EN : ST_PWR;
            req_pwr_o   = IND_ON;
         end
      end

      finish = (st_q == SQ_EXEC)
            || (st_q == SQ_SCAN  && (sel_state_i == ST_EN || idx_q == LAST_IDX))
               && !(st_q == SQ_SCAN && sel_state_i != ST_EN)
            || (st_q == SQ_APPLY && idx_q == LAST_IDX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= SQ_IDLE;
         code_q     <= '0;
         tgt_q      <= '0;
         idx_q      <= '0;
         inv_cmd_q  <= 1'b0;
         inv_mode_q <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         done_q <= (done_q && !done_clr_i) || finish;
         case (st_q)
            SQ_IDLE: begin
               if (accept) begin
                  code_q     <= code_i;
                  tgt_q      <= target_i;
                  idx_q      <= '0;
                  inv_cmd_q  <= 1'b0;
                  inv_mode_q <= 1'b0;
                  st_q       <= (classify(code_i) == CK_ALL) ? SQ_SCAN : SQ_EXEC;
               end
            end
            SQ_EXEC: begin
               case (kind)
                  CK_SLOT:  if (!tgt_ok || reject) inv_cmd_q <= 1'b1;
                  CK_SPEED: if (code_q[2:0] != 3'd0) inv_mode_q <= 1'b1;
                  default:  inv_cmd_q <= 1'b1;
               endcase
               st_q <= SQ_IDLE;
            end
            SQ_SCAN: begin
               if (sel_state_i == ST_EN) begin
                  inv_cmd_q <= 1'b1;
                  st_q      <= SQ_IDLE;
               end else if (idx_q == LAST_IDX) begin
                  idx_q <= '0;
                  st_q  <= SQ_APPLY;
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
               end
            end
            SQ_APPLY: begin
               if (idx_q == LAST_IDX) st_q <= SQ_IDLE;
               else                   idx_q <= idx_q + IDX_W'(1);
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy_o     = (st_q != SQ_IDLE);
   assign inv_cmd_o  = inv_cmd_q;
   assign inv_mode_o = inv_mode_q;
   assign done_o     = done_q;

   // R11: an accepted write makes the engine busy on the next cycle
   assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_i && !busy_o) |=> busy_o);

   // R12: a write during a running command leaves the captured command alone
   assert_ignore_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_i && busy_o) |=> ($stable(code_q) && $stable(tgt_q)));

   // R10: status flags start clear for every accepted command
   assert_status_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_i && !busy_o) |=> (!inv_cmd_o && !inv_mode_o));

   // R10: end of a command always leaves the completion flag set
   assert_done_on_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   // R5: invalid-mode and invalid-command are exclusive
   assert_status_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(inv_mode_o && inv_cmd_o));

endmodule

// File: rtl/hpc_cmd_engine.sv
module hpc_cmd_engine
   import hpc_pkg::*;
#(
   parameter int NSLOTS = 31,
   localparam int IDX_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NSLOTS-1:0]       occupied_i,
   input  logic                    cmd_wr_i,
   input  logic [7:0]              cmd_code_i,
   input  logic [4:0]              cmd_target_i,
   input  logic                    done_clr_i,
   input  logic [NSLOTS-1:0]       evt_clr_i,
   output logic                    busy_o,
   output logic                    inv_cmd_o,
   output logic                    inv_mode_o,
   output logic                    cmd_done_o,
   output logic [2*NSLOTS-1:0]     slot_state_o,
   output logic [2*NSLOTS-1:0]     pwr_ind_o,
   output logic [2*NSLOTS-1:0]     attn_ind_o,
   output logic [NSLOTS-1:0]       latch_open_o,
   output logic [2*NSLOTS-1:0]     presence_o,
   output logic [EVT_W*NSLOTS-1:0] slot_evt_o
);

   if (NSLOTS < 1 || NSLOTS > 31) begin : g_bad_nslots
      $error("hpc_cmd_engine: NSLOTS must lie in 1..31");
   end

   logic [IDX_W-1:0] sel_idx;
   logic             apply;
   logic [1:0]       req_state, req_pwr, req_attn;
   logic [1:0]       sel_state;
   logic             sel_latch;
   logic [1:0]       st_w [NSLOTS];
   logic             lo_w [NSLOTS];

   hpc_cmd_seq #(.NSLOTS(NSLOTS)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_wr_i    (cmd_wr_i),
      .code_i      (cmd_code_i),
      .target_i    (cmd_target_i),
      .done_clr_i  (done_clr_i),
      .sel_state_i (sel_state),
      .sel_latch_i (sel_latch),
      .sel_idx_o   (sel_idx),
      .apply_o     (apply),
      .req_state_o (req_state),
      .req_pwr_o   (req_pwr),
      .req_attn_o  (req_attn),
      .busy_o      (busy_o),
      .inv_cmd_o   (inv_cmd_o),
      .inv_mode_o  (inv_mode_o),
      .done_o      (cmd_done_o)
   );

   always_comb begin
      sel_state = ST_KEEP;
      sel_latch = 1'b0;
      for (int i = 0; i < NSLOTS; i++) begin
         if (sel_idx == IDX_W'(i)) begin
            sel_state = st_w[i];
            sel_latch = lo_w[i];
         end
      end
   end

   for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
      logic       lo;
      logic [1:0] st;
      hpc_slot_cell u_cell (
         .clk          (clk),
         .rst_n        (rst_n),
         .occupied_i   (occupied_i[g]),
         .apply_i      (apply && (sel_idx == IDX_W'(g))),
         .req_state_i  (req_state),
         .req_pwr_i    (req_pwr),
         .req_attn_i   (req_attn),
         .evt_clr_i    (evt_clr_i[g]),
         .state_o      (st),
         .pwr_o        (pwr_ind_o[2*g +: 2]),
         .attn_o       (attn_ind_o[2*g +: 2]),
         .latch_open_o (lo),
         .presence_o   (presence_o[2*g +: 2]),
         .evt_o        (slot_evt_o[EVT_W*g +: EVT_W])
      );
      assign st_w[g]               = st;
      assign lo_w[g]               = lo;
      assign slot_state_o[2*g +: 2] = st;
      assign latch_open_o[g]       = lo;
   end

   // R4: an out-of-range target finishes with invalid-command set
   assert_busy_onecycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy_o) && cmd_code_i[7:6] == 2'b00 && cmd_target_i == 5'd0
       && $past(cmd_wr_i)) |=> (!busy_o && inv_cmd_o));

endmodule

// File: tb/hpc_cmd_engine_tb.sv
module hpc_cmd_engine_tb;

   localparam int NS = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NS-1:0]   occupied = '0;
   logic            cmd_wr = 1'b0;
   logic [7:0]      cmd_code = '0;
   logic [4:0]      cmd_tgt = '0;
   logic            done_clr = 1'b0;
   logic [NS-1:0]   evt_clr = '0;
   logic            busy, inv_cmd, inv_mode, done;
   logic [2*NS-1:0] st_o, pw_o, at_o, pr_o;
   logic [NS-1:0]   lo_o;
   logic [3*NS-1:0] ev_o;

   always #2 clk = ~clk;

   hpc_cmd_engine #(.NSLOTS(NS)) u_dut (
      .clk(clk), .rst_n(rst_n), .occupied_i(occupied), .cmd_wr_i(cmd_wr),
      .cmd_code_i(cmd_code), .cmd_target_i(cmd_tgt), .done_clr_i(done_clr),
      .evt_clr_i(evt_clr), .busy_o(busy), .inv_cmd_o(inv_cmd), .inv_mode_o(inv_mode),
      .cmd_done_o(done), .slot_state_o(st_o), .pwr_ind_o(pw_o), .attn_ind_o(at_o),
      .latch_open_o(lo_o), .presence_o(pr_o), .slot_evt_o(ev_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   int m_st[NS], m_pw[NS], m_at[NS], m_lo[NS], m_pr[NS], m_ev[NS];
   int m_ic, m_im;

   task automatic chk(input string tag, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_slots(input string tag);
      logic [2*NS-1:0] es, ep, ea, er;
      logic [NS-1:0]   el;
      logic [3*NS-1:0] ee;
      for (int i = 0; i < NS; i++) begin
         es[2*i +: 2] = 2'(m_st[i]);
         ep[2*i +: 2] = 2'(m_pw[i]);
         ea[2*i +: 2] = 2'(m_at[i]);
         er[2*i +: 2] = 2'(m_pr[i]);
         el[i]        = 1'(m_lo[i]);
         ee[3*i +: 3] = 3'(m_ev[i]);
      end
      chk(tag, "state",    128'(st_o), 128'(es));
      chk(tag, "power",    128'(pw_o), 128'(ep));
      chk(tag, "attn",     128'(at_o), 128'(ea));
      chk(tag, "presence", 128'(pr_o), 128'(er));
      chk(tag, "latch",    128'(lo_o), 128'(el));
      chk(tag, "events",   128'(ev_o), 128'(ee));
   endtask

   function automatic int mslot(int i, int rs, int pw, int at);
      if (m_st[i] == 2 && rs == 1) return 1;
      if (pw != 0) m_pw[i] = pw;
      if (at != 0) m_at[i] = at;
      if (m_st[i] == 3 && (rs == 1 || rs == 2)) m_st[i] = rs;
      else if ((m_st[i] == 2 || m_st[i] == 1) && rs == 3) begin
         m_st[i] = 3;
         if (m_pw[i] == 3) begin
            m_lo[i] = 1; m_pr[i] = 3; m_ev[i] = 7;
         end
      end
      return 0;
   endfunction

   task automatic model_cmd(input int c, input int t, output int cyc, output string tag);
      int k;
      m_ic = 0; m_im = 0; cyc = 1;
      if (c < 64) begin
         tag = (t < 1 || t > NS) ? "R4" : "R2/R3";
         if (t < 1 || t > NS) m_ic = 1;
         else m_ic = mslot(t - 1, c & 3, (c >> 2) & 3, (c >> 4) & 3);
      end else if (c < 72) begin
         tag = "R5";
         if ((c & 7) != 0) m_im = 1;
      end else if (c == 72 || c == 73) begin
         tag = "R7/R8";
         k = -1;
         for (int i = NS - 1; i >= 0; i--) if (m_st[i] == 2) k = i;
         if (k >= 0) begin
            m_ic = 1; cyc = k + 1;
         end else begin
            cyc = 2 * NS;
            for (int i = 0; i < NS; i++) begin
               if (m_lo[i] == 0) void'(mslot(i, (c == 73) ? 2 : 1, 1, 0));
               else              void'(mslot(i, 0, 3, 0));
            end
         end
      end else begin
         tag = "R6";
         m_ic = 1;
      end
   endtask

   task automatic do_reset(input logic [NS-1:0] occ);
      @(negedge clk);
      rst_n = 1'b0; occupied = occ;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NS; i++) begin
         m_st[i] = occ[i] ? 2 : 3;
         m_pw[i] = occ[i] ? 1 : 3;
         m_lo[i] = occ[i] ? 0 : 1;
         m_pr[i] = occ[i] ? 0 : 3;
         m_at[i] = 0; m_ev[i] = 0;
      end
      m_ic = 0; m_im = 0;
   endtask

   task automatic run_cmd(input logic [7:0] c, input logic [4:0] t, input bit hold_wr);
      int exp_cyc, cyc;
      string tag;
      model_cmd(int'(c), int'(t), exp_cyc, tag);
      @(negedge clk);
      cmd_code = c; cmd_tgt = t; cmd_wr = 1'b1;
      @(negedge clk);
      cyc = 0;
      if (hold_wr) begin
         cmd_code = 8'hAA; cmd_tgt = 5'd1;
         cyc++;
         @(negedge clk);
      end
      cmd_wr = 1'b0;
      while (busy && cyc < 1000) begin
         cyc++;
         @(negedge clk);
      end
      chk(hold_wr ? "R12" : "R11", "busy cycles", 128'(cyc), 128'(exp_cyc));
      chk(tag, "inv_cmd",  128'(inv_cmd),  128'(m_ic));
      chk("R5", "inv_mode", 128'(inv_mode), 128'(m_im));
      chk("R10", "done",   128'(done), 128'd1);
      check_slots(hold_wr ? "R12" : tag);
   endtask

   initial begin
      int unsigned seed;
      logic [7:0] c;
      logic [4:0] t;
      seed = $urandom(32'h5EED_0042);

      // R1: reset with a mixed occupancy pattern
      do_reset(6'b101101);
      chk("R1", "busy", 128'(busy), 128'd0);
      chk("R1", "inv_cmd", 128'(inv_cmd), 128'd0);
      chk("R1", "inv_mode", 128'(inv_mode), 128'd0);
      chk("R1", "done", 128'(done), 128'd0);
      check_slots("R1");

      // R7: all-slot enable aborts on first enabled slot (index 0)
      run_cmd(8'h49, 5'd0, 1'b0);
      // R3: enabled to power-only rejected, indicators untouched
      run_cmd(8'h35, 5'd1, 1'b0);
      // R4: target 0 and target above slot count
      run_cmd(8'h07, 5'd0, 1'b0);
      run_cmd(8'h07, 5'(NS + 1), 1'b0);
      // R2: attention blink only, state keep
      run_cmd(8'h20, 5'd3, 1'b0);
      // R3: disable with power on keeps latch closed
      run_cmd(8'h07, 5'd1, 1'b0);
      run_cmd(8'h07, 5'd3, 1'b0);
      run_cmd(8'h07, 5'd4, 1'b0);
      // R9: disable with power off marks slot 6 empty
      run_cmd(8'h0F, 5'd6, 1'b0);
      // R13: clear slot 6 events
      @(negedge clk); evt_clr = 6'b100000;
      @(negedge clk); evt_clr = '0; m_ev[5] = 0;
      check_slots("R13");
      // R8: power-only all, then R12 held write during enable-all
      run_cmd(8'h48, 5'd0, 1'b0);
      run_cmd(8'h07, 5'd1, 1'b0);
      run_cmd(8'h07, 5'd3, 1'b0);
      run_cmd(8'h07, 5'd4, 1'b0);
      run_cmd(8'h49, 5'd0, 1'b1);
      // R5: accepted and rejected speed modes
      run_cmd(8'h40, 5'd0, 1'b0);
      run_cmd(8'h43, 5'd0, 1'b0);
      // R6: unlisted code
      run_cmd(8'hC5, 5'd2, 1'b0);
      // R10: completion flag clear
      @(negedge clk); done_clr = 1'b1;
      @(negedge clk); done_clr = 1'b0;
      chk("R10", "done after clear", 128'(done), 128'd0);

      // random phase
      for (int n = 0; n < 400; n++) begin
         int r;
         if (n % 60 == 0) do_reset(NS'($urandom));
         r = int'($urandom % 10);
         t = 5'($urandom % 8);
         case (r)
            0, 1, 2, 3: c = 8'($urandom % 64);
            4:          c = 8'h40 + 8'($urandom % 8);
            5, 6:       c = ($urandom % 2) ? 8'h49 : 8'h48;
            7:          c = 8'h4A + 8'($urandom % 182);
            default:    c = ($urandom % 2) ? 8'h07 : 8'h0F;
         endcase
         run_cmd(c, t, 1'b0);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule